// File: doc/BRIEF.md
# SD Card Clock Divider and Gate

This block derives the card clock from a fixed reference clock. Software picks a power-of-two ratio through a 3-bit code. It starts or stops the clock by writing a 3-bit control word whose bits act as one-shot strobes. A running flag shows whether the card clock is actually toggling. After a stop request that flag stays high until the clock has reached a clean low state, so software polls it before it touches the ratio.

When the same control write carries both the start strobe and the start-operation strobe, the block also emits a single-cycle pulse. The command sequencer uses that pulse to launch a command on the freshly started clock. The block only gates and divides. Command framing, data movement and pad drivers sit elsewhere.

Top module: `sd_card_clk_gen`

## Requirements
- R1: While reset is applied and after it is released, `clk_running`, `card_clk` and `op_start` are all 0 until a start is written.
- R2: With ratio code N (0 to 7) the card clock has a period of 2^N reference cycles. For N of 1 or more, it is low for the first 2^(N-1) cycles after `clk_running` rises, then high for 2^(N-1) cycles, and so on. For N = 0 the card clock is high in every high phase of the reference clock. This starts one reference cycle after `clk_running` rises and includes the high phase in which `clk_running` falls.
- R3: A control write with bit 1 (start) set and bit 0 (stop) clear, made while stopped, raises `clk_running` at the next reference edge and captures `div_code` as the active ratio.
- R4: A control write with bit 0 (stop) set, made while running, does not end the clock at once. The card clock runs on until the current period, counted from the start, is complete. `clk_running` falls at that boundary and `card_clk` stays low from then on.
- R5: When bit 0 and bit 1 are set in the same write, the stop takes priority. A stopped clock stays stopped and a running clock begins stopping.
- R6: `op_start` is a one-cycle pulse. It appears in the cycle after a write that has bit 2 (start operation) and bit 1 set and bit 0 clear. Bit 2 alone, or bit 2 together with bit 0, produces no pulse.
- R7: Changes on `div_code` while the clock runs or is stopping have no effect on the card clock. A new code is used only at the next start from the stopped state.
- R8: A start written while a stop is still pending cancels the stop. The clock keeps running with the same ratio and phase.
- R9: A start written while the clock already runs leaves the card clock phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_word | input | 3 | Bit 0 stop, bit 1 start, bit 2 start operation |
| div_code | input | 3 | Ratio code N, divide by 2^N |
| card_clk | output | 1 | Gated, divided card clock |
| clk_running | output | 1 | Card clock running or still finishing its period |
| op_start | output | 1 | One-cycle command launch pulse |

## Verification
The bench drives every ratio code, including the undivided code 0 and the divide-by-128 code 7. A divider tapping the wrong counter bit would show a period off by a factor of two. A design that dropped the clock as soon as a stop arrived would cut a high phase short and lower the running flag too early. The bench also writes start and stop together, from both the stopped and the running state, so an inverted priority would leave the clock running. It changes the ratio code while the clock runs and writes a start during a pending stop. A design that reloaded the code or restarted the counter in those cases would shift the card clock phase. A design that ignored the cancel would stop the clock.

// File: rtl/sd_card_clk_pkg.sv
package sd_card_clk_pkg;
  // control word bit positions, decoded by the software-facing register
  localparam int unsigned CTL_W      = 3;
  localparam int unsigned CTL_STOP   = 0;
  localparam int unsigned CTL_START  = 1;
  localparam int unsigned CTL_OP     = 2;

  typedef enum logic [1:0] {
    GATE_OFF   = 2'd0,
    GATE_RUN   = 2'd1,
    GATE_DRAIN = 2'd2
  } gate_state_e;
endpackage

// File: rtl/sd_card_clk_ctrl.sv
module sd_card_clk_ctrl
  import sd_card_clk_pkg::*;
#(
  parameter int unsigned DIV_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_we,
  input  logic [CTL_W-1:0]     ctl_word,
  input  logic [DIV_W-1:0]     div_code,
  input  logic                 wrap,
  output logic                 running,
  output logic                 cnt_en,
  output logic                 cnt_clr,
  output logic [DIV_W-1:0]     act_code,
  output logic                 op_start
);
  gate_state_e          state_q, state_d;
  logic [DIV_W-1:0]     code_q, code_d;
  logic                 op_q, op_d;
  logic                 stop_req, start_req;

  // stop has priority over start in the same write
  assign stop_req  = ctl_we & ctl_word[CTL_STOP];
  assign start_req = ctl_we & ctl_word[CTL_START] & ~stop_req;
  assign op_d      = start_req & ctl_word[CTL_OP];

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    unique case (state_q)
      GATE_OFF: begin
        if (start_req) begin
          state_d = GATE_RUN;
          code_d  = div_code;
        end
      end
      GATE_RUN: begin
        if (stop_req) state_d = GATE_DRAIN;
      end
      GATE_DRAIN: begin
        if (start_req)  state_d = GATE_RUN;
        else if (wrap)  state_d = GATE_OFF;
      end
      default: state_d = GATE_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GATE_OFF;
      code_q  <= '0;
      op_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      op_q    <= op_d;
    end
  end

  assign running  = (state_q != GATE_OFF);
  assign cnt_en   = running;
  assign cnt_clr  = (state_d == GATE_OFF);
  assign act_code = code_q;
  assign op_start = op_q;
endmodule

// File: rtl/sd_card_clk_div.sv
module sd_card_clk_div #(
  parameter int unsigned DIV_W = 3,
  localparam int unsigned CNT_W = (1 << DIV_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [DIV_W-1:0] code,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   span, mask, cnt_inc;

  // wrap: the next count lands on a whole card clock period
  assign span    = (CNT_W+1)'(1) << code;
  assign mask    = span - (CNT_W+1)'(1);
  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign wrap    = ((cnt_inc & mask) == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/sd_card_clk_gate.sv
module sd_card_clk_gate #(
  parameter int unsigned DIV_W = 3,
  localparam int unsigned NUM_CODES = 1 << DIV_W,
  localparam int unsigned CNT_W = NUM_CODES - 1
) (
  input  logic             clk,
  input  logic             running,
  input  logic [DIV_W-1:0] code,
  input  logic [CNT_W-1:0] cnt,
  output logic             card_clk
);
  logic [NUM_CODES-1:0] tap;
  logic                 en_lat;

  // enable sampled only while the reference clock is low
  always_latch begin
    if (!clk) en_lat = running;
  end

  assign tap[0] = clk & en_lat;

  for (genvar g = 1; g < NUM_CODES; g++) begin : g_tap
    assign tap[g] = cnt[g-1];
  end

  // code is held constant while the clock runs, so the select never moves mid-pulse
  assign card_clk = tap[code];
endmodule

// File: rtl/sd_card_clk_gen.sv
module sd_card_clk_gen
  import sd_card_clk_pkg::*;
#(
  parameter int unsigned DIV_W = 3,
  localparam int unsigned CNT_W = (1 << DIV_W) - 1
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_word,
  input  logic [DIV_W-1:0] div_code,
  output logic             card_clk,
  output logic             clk_running,
  output logic             op_start
);
  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic             wrap, cnt_en, cnt_clr, running;
  logic [DIV_W-1:0] act_code;
  logic [CNT_W-1:0] cnt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  sd_card_clk_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk      (ref_clk),
    .rst_n    (rst_sync_n),
    .ctl_we   (ctl_we),
    .ctl_word (ctl_word),
    .div_code (div_code),
    .wrap     (wrap),
    .running  (running),
    .cnt_en   (cnt_en),
    .cnt_clr  (cnt_clr),
    .act_code (act_code),
    .op_start (op_start)
  );

  sd_card_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk   (ref_clk),
    .rst_n (rst_sync_n),
    .en    (cnt_en),
    .clr   (cnt_clr),
    .code  (act_code),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  sd_card_clk_gate #(.DIV_W(DIV_W)) u_gate (
    .clk      (ref_clk),
    .running  (running),
    .code     (act_code),
    .cnt      (cnt),
    .card_clk (card_clk)
  );

  assign clk_running = running;
endmodule

// File: rtl/sd_card_clk_gen_chk.sv
module sd_card_clk_gen_chk #(
  parameter int unsigned DIV_W = 3
) (
  input logic             ref_clk,
  input logic             rst_ni,
  input logic             ctl_we,
  input logic [2:0]       ctl_word,
  input logic             card_clk,
  input logic             clk_running,
  input logic             op_start,
  input logic [DIV_W-1:0] act_code
);
  assert_stop_wins_R5: assert property (@(posedge ref_clk) disable iff (!rst_ni)
    (ctl_we && ctl_word[0] && !clk_running) |=> !clk_running);

  assert_op_source_R6: assert property (@(posedge ref_clk) disable iff (!rst_ni)
    op_start |-> $past(ctl_we && ctl_word[2] && ctl_word[1] && !ctl_word[0]));

  assert_start_source_R3: assert property (@(posedge ref_clk) disable iff (!rst_ni)
    $rose(clk_running) |-> $past(ctl_we && ctl_word[1] && !ctl_word[0]));

  assert_code_hold_R7: assert property (@(posedge ref_clk) disable iff (!rst_ni)
    (clk_running && $past(clk_running)) |-> $stable(act_code));

  assert_quiet_off_R4: assert property (@(posedge ref_clk) disable iff (!rst_ni)
    !clk_running |-> !card_clk);
endmodule

bind sd_card_clk_gen sd_card_clk_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .ref_clk     (ref_clk),
  .rst_ni      (rst_sync_n),
  .ctl_we      (ctl_we),
  .ctl_word    (ctl_word),
  .card_clk    (card_clk),
  .clk_running (clk_running),
  .op_start    (op_start),
  .act_code    (act_code)
);

// File: tb/sd_card_clk_gen_tb.sv
module sd_card_clk_gen_tb;
  logic       ref_clk = 1'b0;
  logic       rst_n;
  logic       ctl_we;
  logic [2:0] ctl_word;
  logic [2:0] div_code;
  logic       card_clk, clk_running, op_start;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  ck;
    logic  run;
    logic  op;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  // reference model state, derived from the requirements
  int m_run = 0, m_drain = 0, m_j = 0, m_code = 0;
  logic [2:0] cur_div = 3'd0;

  always #10 ref_clk = ~ref_clk;

  sd_card_clk_gen u_dut (
    .ref_clk     (ref_clk),
    .rst_n       (rst_n),
    .ctl_we      (ctl_we),
    .ctl_word    (ctl_word),
    .div_code    (div_code),
    .card_clk    (card_clk),
    .clk_running (clk_running),
    .op_start    (op_start)
  );

  task automatic step(input logic we, input logic [2:0] word, input string tag);
    exp_t e;
    bit stp, sta, op;
    int pre;
    @(negedge ref_clk);
    ctl_we   = we;
    ctl_word = word;
    div_code = cur_div;
    stp = we && word[0];
    sta = we && word[1] && !stp;
    op  = sta && word[2];
    pre = m_run;
    if (m_run == 0) begin
      if (sta) begin m_run = 1; m_code = int'(cur_div); m_j = 0; end
    end else begin
      m_j++;
      if (m_drain != 0) begin
        if (sta) m_drain = 0;
        else if ((m_j % (1 << m_code)) == 0) begin m_run = 0; m_drain = 0; m_j = 0; end
      end else if (stp) m_drain = 1;
    end
    if (m_code == 0) e.ck = (pre != 0);
    else             e.ck = (m_run != 0) && (((m_j >> (m_code - 1)) & 1) != 0);
    e.run = (m_run != 0);
    e.op  = op;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 3'b000, tag);
  endtask

  // monitor: samples mid high phase of the reference clock
  initial begin
    forever begin
      exp_t e;
      @(posedge ref_clk);
      #5;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        checks++;
        if (card_clk !== e.ck || clk_running !== e.run || op_start !== e.op) begin
          errors++;
          $display("FAIL %s: card_clk/running/op_start got %b%b%b expected %b%b%b at %0t",
                   e.tag, card_clk, clk_running, op_start, e.ck, e.run, e.op, $time);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge ref_clk);
    errors++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_we = 1'b0; ctl_word = 3'b000; div_code = 3'd0;
    repeat (3) @(negedge ref_clk);
    // R1: outputs quiet during reset
    checks++;
    if (card_clk !== 1'b0 || clk_running !== 1'b0 || op_start !== 1'b0) begin
      errors++;
      $display("FAIL R1: in reset got %b%b%b expected 000", card_clk, clk_running, op_start);
    end
    rst_n = 1'b1;
    idle(4, "R1");

    // R3 R6 R2: start with command launch, ratio 4
    cur_div = 3'd2;
    step(1'b1, 3'b110, "R6");
    idle(12, "R2");
    // R4: stop drains to period boundary
    step(1'b1, 3'b001, "R4");
    idle(7, "R4");

    // R2: undivided
    cur_div = 3'd0;
    step(1'b1, 3'b010, "R3");
    idle(5, "R2");
    step(1'b1, 3'b001, "R4");
    idle(4, "R4");

    // R2: ratio 2 and ratio 8
    cur_div = 3'd1;
    step(1'b1, 3'b010, "R3");
    idle(6, "R2");
    step(1'b1, 3'b001, "R4");
    idle(4, "R4");
    cur_div = 3'd3;
    step(1'b1, 3'b010, "R3");
    idle(5, "R2");
    // R5: both strobes while running -> stopping
    step(1'b1, 3'b011, "R5");
    idle(10, "R5");
    // R5: both strobes while stopped -> stays stopped, no pulse
    step(1'b1, 3'b111, "R5");
    idle(3, "R5");
    // R6: op bit alone and with stop, no pulse
    step(1'b1, 3'b100, "R6");
    step(1'b1, 3'b101, "R6");
    idle(2, "R6");

    // R7: code change while running ignored, used at next start
    cur_div = 3'd2;
    step(1'b1, 3'b010, "R7");
    idle(3, "R7");
    cur_div = 3'd5;
    idle(9, "R7");
    step(1'b1, 3'b001, "R7");
    idle(6, "R7");
    step(1'b1, 3'b010, "R7");
    idle(40, "R7");
    step(1'b1, 3'b001, "R7");
    idle(34, "R7");

    // R8: start during pending stop cancels it
    cur_div = 3'd4;
    step(1'b1, 3'b010, "R8");
    idle(5, "R8");
    step(1'b1, 3'b001, "R8");
    idle(2, "R8");
    step(1'b1, 3'b010, "R8");
    idle(20, "R8");
    // R9: start while running keeps phase, pulse still issued
    step(1'b1, 3'b110, "R9");
    idle(10, "R9");
    step(1'b1, 3'b001, "R4");
    idle(18, "R4");

    // R2: largest ratio
    cur_div = 3'd7;
    step(1'b1, 3'b010, "R2");
    idle(140, "R2");
    step(1'b1, 3'b001, "R4");
    idle(120, "R4");

    repeat (3) @(posedge ref_clk);
    #8;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule